// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It drives a DAC code and a channel select toward the analog front end, reads back a single comparator bit, and resolves one result bit per conversion-clock tick, starting from the most significant bit. Around that search it runs a scan over a range of up to eight channels. The scan runs once or repeats until software stops it. It is started by one of three selectable sources: a software write, an active-low external pin, or a timer underflow pulse.

Each channel has its own result register with an unread marker. Results read back as 16-bit words, aligned high or low. Two sticky flags, completion and overwrite, feed one interrupt line through per-flag enables. The conversion clock is a tick derived from the peripheral clock by a power-of-two divider. A sampling window of 3 to 10 ticks precedes the 10 decision ticks.

Top module: `sar_seq_top`

## Requirements
- R1: With the comparator high whenever the analog level is at or above the DAC code, each conversion resolves bits 9 down to 0 and stores the largest code the level reaches, i.e. the level clipped to 0..1023.
- R2: One channel takes 13+S conversion ticks, S being CTRL bits 13:11. The tick period is 2^(D+1) clock cycles, D being the register at address 1, bits 3:0, in the range 0..14.
- R3: A scan converts channels from FIRST (CTRL bits 7:5) up to LAST (CTRL bits 10:8), counting modulo 8 so that it wraps past 7. The channel being converted appears on chan_sel. Each result goes only to the register at address 8+channel.
- R4: With CTRL bit 3 low (single pass), the run bit (CTRL bit 0) clears itself after the last channel, and the busy bit (CTRL read bit 14) returns to 0.
- R5: With CTRL bit 3 high, the scan restarts at FIRST after LAST while run stays 1. A write that clears run makes busy read 0 at once.
- R6: CTRL bits 2:1 pick the start source: 0 for a CTRL write with run=1, 1 for a falling edge of ext_trig_n after a two-flop synchronizer, and 2 for a tmr_uflow pulse. Unselected sources are ignored, and so are triggers that arrive while busy.
- R7: A result reads as {6'b0,value} when CTRL bit 4 is 0, and as {value,6'b0} when it is 1.
- R8: The completion flag (address 2, bit 0) is set by every finished channel. It stays set until a write of 1 to that bit.
- R9: The overwrite flag (address 2, bit 1) is set when a channel completes while its previous result is still unread. Reading a result register clears that channel's unread marker. A write of 1 clears the flag.
- R10: irq equals (completion AND enable bit 8) OR (overwrite AND enable bit 9) of address 2.
- R11: After reset all registers read 0, the block is idle, dac_code is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears unread marker on result reads) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cmp_hi | input | 1 | Comparator: analog level at or above dac_code |
| dac_code | output | 10 | Trial code for the DAC |
| chan_sel | output | 3 | Analog multiplexer select |
| ext_trig_n | input | 1 | External start, active low, asynchronous |
| tmr_uflow | input | 1 | Timer underflow start pulse |
| irq | output | 1 | Interrupt request |

## Verification
The search is swept over all 1024 comparator thresholds, which separates a wrong bit order, a lost LSB decision and an off-by-one trial code. Multi-channel scans with distinct levels per channel, including a scan that wraps past channel 7, tell apart misrouted results and a wrong end condition. A sweep over every sampling setting and three divider values measures the spacing of channel changes, which shows an extra or missing sample or decision tick. The trigger tests pulse every unselected source and retrigger during a conversion, so a start from the wrong source and a restart while busy are both visible.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int RES_W    = 10;
    localparam int CH_N     = 8;
    localparam int CH_W     = $clog2(CH_N);
    localparam int SMP_W    = 3;
    localparam int DIV_W    = 4;
    localparam int CNT_W    = 15;
    localparam int BASE_SMP = 3;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 16;
    localparam int BIDX_W   = $clog2(RES_W);
    localparam int TCNT_W   = $clog2(RES_W + BASE_SMP + (1 << SMP_W));

    typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_BITS} eng_st_t;
    typedef enum logic [1:0] {TRG_SOFT = 2'd0, TRG_EXT = 2'd1, TRG_TMR = 2'd2, TRG_NONE = 2'd3} trg_src_t;

    typedef struct packed {
        logic [SMP_W-1:0] smp;
        logic [CH_W-1:0]  last;
        logic [CH_W-1:0]  first;
        logic             left;
        logic             cont;
        trg_src_t         src;
        logic             run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic             valid;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] val;
    } result_t;

    function automatic logic [DATA_W-1:0] fmt_result(logic [RES_W-1:0] v, logic left);
        return left ? {v, {(DATA_W-RES_W){1'b0}}} : {{(DATA_W-RES_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv import sar_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div_c;
    logic [CNT_W-1:0] mask;

    always_comb begin
        div_c = (32'(div) > CNT_W - 1) ? DIV_W'(CNT_W - 1) : div;
        mask  = ~({CNT_W{1'b1}} << (32'(div_c) + 1));
        tick  = (cnt & mask) == mask;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/sar_trig.sv
module sar_trig import sar_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  trg_src_t src,
    input  logic     soft_go,
    input  logic     ext_n,
    input  logic     tmr_pulse,
    output logic     trig
);
    logic [2:0] sync_q;
    logic       ext_fall;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b111;
        else     sync_q <= {sync_q[1:0], ext_n};
    end

    assign ext_fall = sync_q[2] & ~sync_q[1];

    always_comb begin
        case (src)
            TRG_SOFT: trig = soft_go;
            TRG_EXT:  trig = ext_fall;
            TRG_TMR:  trig = tmr_pulse;
            default:  trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/sar_engine.sv
module sar_engine import sar_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             trig,
    input  ctrl_t            ctrl,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic [CH_W-1:0]  chan,
    output logic             busy,
    output logic             scan_end,
    output result_t          done
);
    eng_st_t           st;
    logic [BIDX_W-1:0] bidx;
    logic [BIDX_W-1:0] cnt;
    logic [RES_W-1:0]  sar, trial, nxt;
    logic [TCNT_W-1:0] tcnt;   // ticks in the current conversion, for R2 check

    always_comb begin
        trial    = sar | (RES_W'(1) << bidx);
        nxt      = cmp_hi ? trial : sar;
        dac_code = (st == ST_BITS) ? trial : '0;
        busy     = (st != ST_IDLE) && ctrl.run;
        done.valid = (st == ST_BITS) && tick && (bidx == '0) && ctrl.run;
        done.ch    = chan;
        done.val   = nxt;
        scan_end   = done.valid && (chan == ctrl.last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            chan <= '0;
            cnt  <= '0;
            bidx <= '0;
            sar  <= '0;
            tcnt <= '0;
        end else if (st != ST_IDLE && !ctrl.run) begin
            st <= ST_IDLE;                               // R5: stop at once
        end else begin
            case (st)
                ST_IDLE: if (ctrl.run && trig) begin     // R6: triggers only seen here
                    st   <= ST_SAMPLE;
                    chan <= ctrl.first;
                    cnt  <= '0;
                    tcnt <= '0;
                end
                ST_SAMPLE: if (tick) begin
                    tcnt <= tcnt + TCNT_W'(1);
                    if (cnt == BIDX_W'(ctrl.smp) + BIDX_W'(BASE_SMP - 1)) begin
                        st   <= ST_BITS;
                        bidx <= BIDX_W'(RES_W - 1);
                        sar  <= '0;
                    end else begin
                        cnt <= cnt + BIDX_W'(1);
                    end
                end
                ST_BITS: if (tick) begin                 // R1: one decision per tick
                    tcnt <= tcnt + TCNT_W'(1);
                    sar  <= nxt;
                    bidx <= bidx - BIDX_W'(1);
                    if (bidx == '0) begin
                        cnt  <= '0;
                        tcnt <= '0;
                        if (chan == ctrl.last) begin     // R3, R4, R5
                            st   <= ctrl.cont ? ST_SAMPLE : ST_IDLE;
                            chan <= ctrl.cont ? ctrl.first : chan;
                        end else begin
                            st   <= ST_SAMPLE;
                            chan <= chan + CH_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r2_conv_len: assert property (@(posedge clk) disable iff (rst)
        done.valid |-> (tcnt == TCNT_W'(ctrl.smp) + TCNT_W'(RES_W + BASE_SMP - 1)));

    a_r1_bit_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BITS && tick && bidx != '0 && ctrl.run) |=> (bidx == $past(bidx) - BIDX_W'(1)));

    a_r1_dac_idle: assert property (@(posedge clk) disable iff (rst)
        (st != ST_BITS) |-> (dac_code == '0));
endmodule

// File: rtl/sar_regs.sv
module sar_regs import sar_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              scan_end,
    input  result_t           done,
    output ctrl_t             ctrl_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              soft_go,
    output logic              irq
);
    logic [RES_W-1:0] res [CH_N];
    logic [CH_N-1:0]  unread;
    logic             done_f, ovr_f, den, oen;
    logic             wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            soft_go <= 1'b0;
            unread  <= '0;
            done_f  <= 1'b0;
            ovr_f   <= 1'b0;
            den     <= 1'b0;
            oen     <= 1'b0;
            for (int i = 0; i < CH_N; i++) res[i] <= '0;
        end else begin
            soft_go <= 1'b0;
            if (scan_end && !ctrl_q.cont) ctrl_q.run <= 1'b0;      // R4
            if (we) begin
                case (addr)
                    ADDR_W'(0): begin
                        ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
                        soft_go <= wdata[0] && (trg_src_t'(wdata[2:1]) == TRG_SOFT);
                    end
                    ADDR_W'(1): div_q <= wdata[DIV_W-1:0];
                    ADDR_W'(2): begin
                        if (wdata[0]) done_f <= 1'b0;              // R8
                        if (wdata[1]) ovr_f  <= 1'b0;              // R9
                        den <= wdata[8];
                        oen <= wdata[9];
                    end
                    default: ;
                endcase
            end
            if (re && addr[ADDR_W-1]) unread[addr[CH_W-1:0]] <= 1'b0;
            if (done.valid) begin
                res[done.ch]    <= done.val;
                unread[done.ch] <= 1'b1;
                done_f          <= 1'b1;
                if (unread[done.ch]) ovr_f <= 1'b1;
            end
        end
    end

    always_comb begin
        if (addr[ADDR_W-1]) begin
            rdata = fmt_result(res[addr[CH_W-1:0]], ctrl_q.left);   // R7
        end else begin
            case (addr)
                ADDR_W'(0): rdata = {{(DATA_W-CTRL_W-1){1'b0}}, busy, ctrl_q};
                ADDR_W'(1): rdata = DATA_W'(div_q);
                ADDR_W'(2): rdata = DATA_W'({oen, den, 6'b0, ovr_f, done_f});
                default:    rdata = '0;
            endcase
        end
    end

    assign irq = (done_f & den) | (ovr_f & oen);                   // R10

    a_r8_done_set: assert property (@(posedge clk) disable iff (rst)
        done.valid |=> done_f);

    a_r9_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_f) |-> $past(done.valid && unread[done.ch]));

    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (scan_end && !ctrl_q.cont && !(we && addr == '0)) |=> !ctrl_q.run);

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (!den && !oen) |-> !irq);
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top import sar_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmp_hi,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   chan_sel,
    input  logic              ext_trig_n,
    input  logic              tmr_uflow,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    logic             tick, soft_go, trig, busy, scan_end;
    result_t          done;

    sar_clkdiv u_div (.clk(clk), .rst(rst), .div(div), .tick(tick));

    sar_trig u_trig (
        .clk(clk), .rst(rst), .src(ctrl.src), .soft_go(soft_go),
        .ext_n(ext_trig_n), .tmr_pulse(tmr_uflow), .trig(trig)
    );

    sar_engine u_eng (
        .clk(clk), .rst(rst), .tick(tick), .trig(trig), .ctrl(ctrl),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .chan(chan_sel),
        .busy(busy), .scan_end(scan_end), .done(done)
    );

    sar_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
        .scan_end(scan_end), .done(done), .ctrl_q(ctrl), .div_q(div),
        .soft_go(soft_go), .irq(irq)
    );
endmodule

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmp_hi;
    logic [9:0]  dac_code;
    logic [2:0]  chan_sel;
    logic        ext_trig_n = 1'b1, tmr_uflow = 1'b0;
    logic        irq;
    logic [9:0]  tgt [8];
    int          total = 0, fails = 0;

    always #10 clk = ~clk;

    assign cmp_hi = (tgt[chan_sel] >= dac_code);

    sar_seq_top u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(bit run, int src, bit cont, bit left, int first, int last, int smp);
        return {2'b0, 3'(smp), 3'(last), 3'(first), left, cont, 2'(src), run};
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk); reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk); reg_addr = 4'(a); reg_re = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3000; i++) begin
            reg_addr = 4'd0; #1;
            if (!reg_rdata[14]) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic convert(input logic [15:0] c, input string req);
        bit ok;
        wr(0, c);
        wait_idle(ok);
        check(ok, req, 0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] d;
        bit ok;
        for (int i = 0; i < 8; i++) tgt[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(0, d);  check(d == 0, "R11 ctrl", d, 0);
        rd(2, d);  check(d == 0, "R11 irq reg", d, 0);
        rd(11, d); check(d == 0, "R11 result", d, 0);
        check(dac_code == 0 && irq == 0, "R11 outputs", {dac_code, irq}, 0);

        // R1 exhaustive threshold sweep on channel 0
        wr(1, 16'd0);
        for (int v = 0; v < 1024; v++) begin
            tgt[0] = 10'(v);
            convert(mk(1, 0, 0, 0, 0, 0, 0), "R4 idle");
            rd(8, d);
            check(d == 16'(v), "R1 sar result", d, v);
        end
        rd(0, d); check(d[0] == 1'b0 && d[14] == 1'b0, "R4 run cleared", d, 0);

        // R7 left alignment
        tgt[0] = 10'h2AB;
        convert(mk(1, 0, 0, 1, 0, 0, 0), "R7 idle");
        rd(8, d); check(d == {10'h2AB, 6'b0}, "R7 left", d, {10'h2AB, 6'b0});
        wr(0, mk(0, 0, 0, 0, 0, 0, 0));
        rd(8, d); check(d == 16'h02AB, "R7 right", d, 16'h02AB);

        // R3 scan 2..5 and wrapping scan 6..1
        for (int c = 0; c < 8; c++) tgt[c] = 10'(37 * c + 100);
        convert(mk(1, 0, 0, 0, 2, 5, 0), "R3 idle");
        for (int c = 2; c <= 5; c++) begin
            rd(8 + c, d); check(d == 16'(37 * c + 100), "R3 scan", d, 37 * c + 100);
        end
        for (int c = 0; c < 8; c++) tgt[c] = 10'(900 - 50 * c);
        convert(mk(1, 0, 0, 0, 6, 1, 0), "R3 idle wrap");
        for (int k = 0; k < 4; k++) begin
            int c = (6 + k) % 8;
            rd(8 + c, d); check(d == 16'(900 - 50 * c), "R3 wrap", d, 900 - 50 * c);
        end
        rd(10, d); check(d == 16'(37 * 2 + 100), "R3 untouched ch2", d, 37 * 2 + 100);

        // R2 timing sweep: spacing between chan_sel changes
        for (int dv = 0; dv < 3; dv++) begin
            for (int s = 0; s < 8; s++) begin
                int t1, t2, exp;
                t1 = -1; t2 = -1;
                wr(1, 16'(dv));
                wr(0, mk(1, 0, 0, 0, 0, 3, s));
                @(negedge clk);
                for (int k = 0; k < 4000 && t2 < 0; k++) begin
                    @(negedge clk);
                    if (chan_sel == 3'd1 && t1 < 0) t1 = k;
                    if (chan_sel == 3'd2 && t2 < 0) t2 = k;
                end
                exp = (13 + s) << (dv + 1);
                check(t2 - t1 == exp, "R2 conversion length", t2 - t1, exp);
                wait_idle(ok);
                check(ok, "R2 idle", 0, 1);
            end
        end
        wr(1, 16'd0);

        // R5 continuous mode and immediate stop
        wr(0, mk(1, 0, 1, 0, 0, 1, 0));
        repeat (200) @(negedge clk);
        rd(0, d); check(d[14] && d[0], "R5 still running", d, 16'h4000);
        wr(0, mk(0, 0, 1, 0, 0, 1, 0));
        reg_addr = 4'd0; #1;
        check(reg_rdata[14] == 1'b0, "R5 stop busy", reg_rdata[14], 0);
        repeat (2) @(negedge clk);
        check(dac_code == 0, "R5 stop dac", dac_code, 0);
        rd(2, d); check(d[1:0] == 2'b11, "R9 continuous overwrite", d[1:0], 3);

        // R8 R9 R10 flags and interrupt
        wr(2, 16'h0003);
        for (int c = 0; c < 8; c++) rd(8 + c, d);
        rd(2, d); check(d == 0, "R8 cleared", d, 0);
        tgt[0] = 10'd512;
        convert(mk(1, 0, 0, 0, 0, 0, 0), "R8 idle");
        rd(2, d); check(d[1:0] == 2'b01, "R8 done set", d[1:0], 1);
        check(irq == 1'b0, "R10 disabled", irq, 0);
        wr(2, 16'h0100);
        check(irq == 1'b1, "R10 done enabled", irq, 1);
        convert(mk(1, 0, 0, 0, 0, 0, 0), "R9 idle");
        rd(2, d); check(d[1:0] == 2'b11, "R9 overwrite set", d[1:0], 3);
        wr(2, 16'h0101);
        rd(2, d); check(d[1:0] == 2'b10, "R8 w1c done", d[1:0], 2);
        check(irq == 1'b0, "R10 ovr masked", irq, 0);
        wr(2, 16'h0200);
        check(irq == 1'b1, "R10 ovr enabled", irq, 1);
        wr(2, 16'h0202);
        check(irq == 1'b0, "R9 w1c ovr", irq, 0);
        rd(8, d);
        convert(mk(1, 0, 0, 0, 0, 0, 0), "R9 idle2");
        rd(2, d); check(d[1] == 1'b0, "R9 read clears unread", d[1], 0);
        wr(2, 16'h0003);

        // R6 external trigger: other sources ignored
        tgt[0] = 10'd321;
        wr(0, mk(1, 1, 0, 0, 0, 0, 0));
        @(negedge clk); tmr_uflow = 1'b1; @(negedge clk); tmr_uflow = 1'b0;
        repeat (40) @(negedge clk);
        rd(0, d); check(d[14] == 1'b0 && d[0], "R6 ext armed, others ignored", d[14], 0);
        begin
            int rise, fall;
            rise = -1; fall = -1;
            reg_addr = 4'd0;
            ext_trig_n = 1'b0;
            for (int k = 1; k < 80 && fall < 0; k++) begin
                @(negedge clk);
                if (k == 3) ext_trig_n = 1'b1;
                if (k == 12) ext_trig_n = 1'b0;
                if (k == 15) ext_trig_n = 1'b1;
                #1;
                if (reg_rdata[14] && rise < 0) rise = k;
                if (!reg_rdata[14] && rise >= 0 && fall < 0) fall = k;
            end
            check(rise == 3, "R6 ext start latency", rise, 3);
            check(fall >= 26 && fall <= 32, "R6 retrigger ignored", fall, 28);
        end
        rd(8, d); check(d == 16'd321, "R6 ext result", d, 321);

        // R6 timer trigger
        tgt[0] = 10'd77;
        wr(0, mk(1, 2, 0, 0, 0, 0, 0));
        @(negedge clk); ext_trig_n = 1'b0; repeat (3) @(negedge clk); ext_trig_n = 1'b1;
        repeat (30) @(negedge clk);
        rd(0, d); check(d[14] == 1'b0 && d[0], "R6 timer armed, ext ignored", d[14], 0);
        @(negedge clk); tmr_uflow = 1'b1; @(negedge clk); tmr_uflow = 1'b0;
        #1 check(reg_rdata[14] == 1'b1, "R6 timer start", reg_rdata[14], 1);
        wait_idle(ok); check(ok, "R6 timer idle", 0, 1);
        rd(8, d); check(d == 16'd77, "R6 timer result", d, 77);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule